// File: doc/BRIEF.md
# Microcoded SDRAM Command Sequencer

This block drives the control pins of an SDRAM from a sixteen-entry table of 12-bit command words. Each word gives the two bank-select bits, clock enable, address bit 10, the four active-low strobes (chip select, row strobe, column strobe, write enable) and a 4-bit link to the entry that follows. The sequencer walks the table on its own. A NOP leads into self-refresh, self-refresh leads into an exit word, and the exit word leads back to the NOP. Precharge, mode-load, read and write words return to a fixed entry when they finish.

A host-side controller steers the walk with a request port that carries a command code, a bank and an address. It also has a separate init strobe that selects the mode-register load. A request is honoured only in the states that allow it. When a request is honoured, its bank and address are captured and merged into the table's bits on later cycles. A request that is not allowed changes nothing and raises a one-cycle reject flag. Every pin leaves the block through a register, so a table entry reaches the pins one clock after the entry becomes current.

Top module: `sdramCmdSeq`

## Requirements
- R1: After reset the current entry is the deselect word. The pins show chip select, row, column and write strobes all high, CKE high, BA = 3 and address bit 10 set. With no request, the deselect word repeats.
- R2: An init strobe is legal while the NOP or the deselect word is current. It issues a mode load one cycle later: BA = 0, CKE high, all four strobes low, address bit 10 low, and the other address bits equal to the request address. A NOP follows.
- R3: Without requests, the table cycles through three words. The NOP has CKE high, chip select low, the other strobes high, BA = 3 and address 0x400. Self-refresh entry has CKE low, chip select, row and column strobes low and write enable high. The refresh exit word is coded like the NOP. The cycle then returns to the NOP.
- R4: An activate request (code 0) is accepted only while the NOP is current. The activate word drives row strobe low, column and write strobes high, BA = the requested bank, and the address = the requested row, with bit 10 taken from the request. The word repeats until another request is accepted.
- R5: A read request (code 1) is accepted only while the activate word is current. The read word drives column strobe low and the other strobes as for a read: chip select low, row strobe high, write enable high. It carries BA = the requested bank and the address = the request with bit 10 cleared. The activate word follows.
- R6: A write request (code 2) behaves as R5, except that write enable is also low.
- R7: A precharge request (code 3) for bank n is accepted while the NOP or the activate word is current. It drives BA = n, address 0, chip select, row strobe and write enable low, and column strobe high. A NOP follows.
- R8: A request or init in any other state is ignored: the table walk continues unchanged, and the reject output is high in the cycle the pins show the next word. The refresh exit word is never interrupted.
- R9: When init and a request arrive in the same cycle, init takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low synchronous reset |
| initReq | input | 1 | Jump to the mode-register load (address carries the mode) |
| reqValid | input | 1 | Command request strobe |
| reqCmd | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| reqBank | input | 2 | Requested bank |
| reqAddr | input | ADDR_W | Row, column or mode value |
| sdBa | output | 2 | Bank select, bit 0 = BA0 |
| sdCke | output | 1 | Clock enable |
| sdAddr | output | ADDR_W | Address bus |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| reqReject | output | 1 | One-cycle flag for a request that was not allowed |

## Verification
The hardest state to reach is the NOP. It is current for only one cycle out of every three in the free-running refresh loop, and it is the only state that admits an activate or an init from idle. A bench that issued requests without regard to timing would land mostly on the refresh words and would see only rejects. The stimulus therefore tracks the table position in its own model and idles until that position reaches the NOP. Once there, it fires an activate, a precharge or an init at that exact cycle. The same timing is used to aim a request deliberately at the refresh-exit word, to show that this word cannot be interrupted.

// File: rtl/sdSeqPkg.sv
package sdSeqPkg;

  typedef struct packed {
    logic       ba0;
    logic       ba1;
    logic       cke;
    logic       a10;
    logic       csN;
    logic       rasN;
    logic       casN;
    logic       weN;
    logic [3:0] link;
  } microWord_t;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } reqCmd_t;

  localparam logic [3:0] ENT_NOP   = 4'h0;
  localparam logic [3:0] ENT_SRF   = 4'h1;
  localparam logic [3:0] ENT_SRX   = 4'h2;
  localparam logic [3:0] ENT_MODE  = 4'h3;
  localparam logic [3:0] ENT_DESEL = 4'h4;
  localparam logic [3:0] ENT_PRE0  = 4'h5;
  localparam logic [3:0] ENT_ACT   = 4'h9;
  localparam logic [3:0] ENT_RD    = 4'hA;
  localparam logic [3:0] ENT_WR    = 4'hB;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadRow;
    logic loadCol;
    logic reject;
  } strobe_t;

  function automatic microWord_t romWord(input logic [3:0] entry);
    logic [11:0] w;
    case (entry)
      4'h0:    w = 12'hF71;  // NOP, on to self-refresh
      4'h1:    w = 12'hD12;  // self-refresh entry
      4'h2:    w = 12'hF70;  // refresh exit, NOP-coded
      4'h3:    w = 12'h200;  // mode load
      4'h4:    w = 12'hFF4;  // deselect, loops
      4'h5:    w = 12'h220;  // precharge bank 0
      4'h6:    w = 12'hA20;  // precharge bank 1
      4'h7:    w = 12'h620;  // precharge bank 2
      4'h8:    w = 12'hE20;  // precharge bank 3
      4'h9:    w = 12'h239;  // activate, holds
      4'hA:    w = 12'h259;  // read
      4'hB:    w = 12'h249;  // write
      default: w = 12'hF70;  // spare: NOP to entry 0
    endcase
    return microWord_t'(w);
  endfunction

endpackage

// File: rtl/sdSeqCtrl.sv
module sdSeqCtrl
  import sdSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       initReq,
  input  logic       reqValid,
  input  logic [1:0] reqCmd,
  input  logic [1:0] reqBank,
  output logic [3:0] curAddr,
  output strobe_t    strobes
);

  microWord_t curWord;
  logic [3:0] nextAddr;
  logic       atIdle;
  logic       atAct;

  assign curWord = romWord(curAddr);
  assign atIdle  = (curAddr == ENT_NOP);
  assign atAct   = (curAddr == ENT_ACT);

  always_comb begin
    nextAddr = curWord.link;
    strobes  = '0;
    if (initReq) begin
      if (atIdle || curAddr == ENT_DESEL) begin
        nextAddr        = ENT_MODE;
        strobes.loadCol = 1'b1;
      end else begin
        strobes.reject = 1'b1;
      end
    end else if (reqValid) begin
      case (reqCmd_t'(reqCmd))
        CMD_ACT: begin
          if (atIdle) begin
            nextAddr        = ENT_ACT;
            strobes.loadRow = 1'b1;
          end else strobes.reject = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (atAct) begin
            nextAddr        = (reqCmd_t'(reqCmd) == CMD_RD) ? ENT_RD : ENT_WR;
            strobes.loadCol = 1'b1;
          end else strobes.reject = 1'b1;
        end
        default: begin
          if (atIdle || atAct) nextAddr = ENT_PRE0 + {2'b00, reqBank};
          else strobes.reject = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) curAddr <= ENT_DESEL;
    else       curAddr <= nextAddr;
  end

endmodule

// File: rtl/sdSeqDatapath.sv
module sdSeqDatapath
  import sdSeqPkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int A10_POS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        curAddr,
  input  strobe_t           strobes,
  input  logic [1:0]        reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        sdBa,
  output logic              sdCke,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              reqReject
);

  localparam logic [ADDR_W-1:0] A10_MASK = ADDR_W'(1) << A10_POS;

  logic [1:0]        rowBank, colBank;
  logic [ADDR_W-1:0] rowAddr, colAddr;
  microWord_t        w;
  microWord_t        deselWord;
  logic [1:0]        nBa;
  logic [ADDR_W-1:0] nAddr, romA10;

  assign w         = romWord(curAddr);
  assign deselWord = romWord(ENT_DESEL);
  assign romA10    = w.a10 ? A10_MASK : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowBank <= '0;
      rowAddr <= '0;
      colBank <= '0;
      colAddr <= '0;
    end else begin
      if (strobes.loadRow) begin
        rowBank <= reqBank;
        rowAddr <= reqAddr;
      end
      if (strobes.loadCol) begin
        colBank <= reqBank;
        colAddr <= reqAddr & ~A10_MASK;
      end
    end
  end

  always_comb begin
    nBa   = {w.ba1, w.ba0};
    nAddr = romA10;
    case (curAddr)
      ENT_ACT: begin
        nBa   = nBa | rowBank;
        nAddr = rowAddr | romA10;
      end
      ENT_RD, ENT_WR: begin
        nBa   = nBa | colBank;
        nAddr = colAddr | romA10;
      end
      ENT_MODE: nAddr = colAddr | romA10;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdBa      <= {deselWord.ba1, deselWord.ba0};
      sdCke     <= deselWord.cke;
      sdAddr    <= deselWord.a10 ? A10_MASK : '0;
      sdCsN     <= deselWord.csN;
      sdRasN    <= deselWord.rasN;
      sdCasN    <= deselWord.casN;
      sdWeN     <= deselWord.weN;
      reqReject <= 1'b0;
    end else begin
      sdBa      <= nBa;
      sdCke     <= w.cke;
      sdAddr    <= nAddr;
      sdCsN     <= w.csN;
      sdRasN    <= w.rasN;
      sdCasN    <= w.casN;
      sdWeN     <= w.weN;
      reqReject <= strobes.reject;
    end
  end

endmodule

// File: rtl/sdramCmdSeq.sv
module sdramCmdSeq
  import sdSeqPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic [1:0]        reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        sdBa,
  output logic              sdCke,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              reqReject
);

  logic [3:0] curAddr;
  strobe_t    strobes;

  sdSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .reqValid(reqValid),
    .reqCmd(reqCmd), .reqBank(reqBank), .curAddr(curAddr), .strobes(strobes)
  );

  sdSeqDatapath #(.ADDR_W(ADDR_W), .A10_POS(10)) uData (
    .clk(clk), .rstN(rstN), .curAddr(curAddr), .strobes(strobes),
    .reqBank(reqBank), .reqAddr(reqAddr),
    .sdBa(sdBa), .sdCke(sdCke), .sdAddr(sdAddr), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .reqReject(reqReject)
  );

endmodule

// File: rtl/sdramCmdSeqChk.sv
module sdramCmdSeqChk (
  input logic clk,
  input logic rstN,
  input logic initReq,
  input logic reqValid,
  input logic sdCke,
  input logic sdCsN,
  input logic sdRasN,
  input logic sdCasN,
  input logic sdWeN,
  input logic reqReject
);

  logic nopPins, actPins, rdwrPins, prePins, modePins;
  assign nopPins  = sdCke && !sdCsN && sdRasN && sdCasN && sdWeN;
  assign actPins  = sdCke && !sdCsN && !sdRasN && sdCasN && sdWeN;
  assign rdwrPins = !sdCsN && sdRasN && !sdCasN;
  assign prePins  = !sdCsN && !sdRasN && sdCasN && !sdWeN;
  assign modePins = !sdCsN && !sdRasN && !sdCasN && !sdWeN;

  // R3
  srf_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdCke |-> (!sdCsN && !sdRasN && !sdCasN && sdWeN));

  // R3
  srf_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdCke) |=> nopPins);

  // R2
  mode_then_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    modePins |=> nopPins);

  // R4
  act_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actPins && !$past(actPins)) |-> $past(nopLikeOrCol()));

  // R5
  rdwr_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdwrPins |=> actPins);

  // R7
  pre_then_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    prePins |=> nopPins);

  // R8
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> $past(reqValid || initReq));

  function automatic logic nopLikeOrCol();
    return nopPins || rdwrPins;
  endfunction

endmodule

bind sdramCmdSeq sdramCmdSeqChk uChk (
  .clk(clk), .rstN(rstN), .initReq(initReq), .reqValid(reqValid),
  .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdWeN(sdWeN), .reqReject(reqReject)
);

// File: tb/sim_sdramCmdSeq.sv
module sim_sdramCmdSeq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          initReq = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqCmd = '0;
  logic [1:0]    reqBank = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    sdBa;
  logic          sdCke, sdCsN, sdRasN, sdCasN, sdWeN, reqReject;
  logic [AW-1:0] sdAddr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  typedef struct {
    logic [18:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  // reference model state
  int            mAddr = 4;
  logic [1:0]    rowB = '0, colB = '0;
  logic [AW-1:0] rowA = '0, colA = '0;

  sdramCmdSeq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .initReq(initReq), .reqValid(reqValid),
    .reqCmd(reqCmd), .reqBank(reqBank), .reqAddr(reqAddr),
    .sdBa(sdBa), .sdCke(sdCke), .sdAddr(sdAddr), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .reqReject(reqReject)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [18:0] pack(logic [1:0] ba, logic cke, logic [AW-1:0] a,
                                       logic cs, logic ras, logic cas, logic we, logic rej);
    return {ba, cke, a, cs, ras, cas, we, rej};
  endfunction

  function automatic logic [18:0] actual();
    return {sdBa, sdCke, sdAddr, sdCsN, sdRasN, sdCasN, sdWeN, reqReject};
  endfunction

  // expected pins for the model's current entry, per R1..R7
  function automatic logic [18:0] modelPins(logic rej);
    case (mAddr)
      1:       return pack(2'd3, 1'b0, 11'h400, 0, 0, 0, 1, rej);
      3:       return pack(2'd0, 1'b1, colA & ~11'h400, 0, 0, 0, 0, rej);
      4:       return pack(2'd3, 1'b1, 11'h400, 1, 1, 1, 1, rej);
      5, 6, 7, 8: return pack(2'(mAddr - 5), 1'b1, 11'h000, 0, 0, 1, 0, rej);
      9:       return pack(rowB, 1'b1, rowA, 0, 0, 1, 1, rej);
      10:      return pack(colB, 1'b1, colA & ~11'h400, 0, 1, 0, 1, rej);
      11:      return pack(colB, 1'b1, colA & ~11'h400, 0, 1, 0, 0, rej);
      default: return pack(2'd3, 1'b1, 11'h400, 0, 1, 1, 1, rej);
    endcase
  endfunction

  task automatic cyc(input logic iv, input logic v, input logic [1:0] cmd,
                     input logic [1:0] bank, input logic [AW-1:0] a, input string tag);
    exp_t e;
    int   nxt;
    logic bad;
    @(negedge clk);
    initReq = iv; reqValid = v; reqCmd = cmd; reqBank = bank; reqAddr = a;
    bad = 1'b0;
    case (mAddr)
      0: nxt = 1;  1: nxt = 2;  2: nxt = 0;  4: nxt = 4;
      9, 10, 11: nxt = 9;
      default: nxt = 0;
    endcase
    if (iv) begin
      if (mAddr == 0 || mAddr == 4) nxt = 3; else bad = 1'b1;
    end else if (v) begin
      case (cmd)
        2'd0: if (mAddr == 0) nxt = 9; else bad = 1'b1;
        2'd1: if (mAddr == 9) nxt = 10; else bad = 1'b1;
        2'd2: if (mAddr == 9) nxt = 11; else bad = 1'b1;
        default: if (mAddr == 0 || mAddr == 9) nxt = 5 + int'(bank); else bad = 1'b1;
      endcase
    end
    e.val = modelPins(bad);
    e.tag = tag;
    q.push_back(e);
    if (!bad && iv) begin colA = a; colB = bank; end
    if (!bad && !iv && v && cmd == 2'd0) begin rowA = a; rowB = bank; end
    if (!bad && !iv && v && (cmd == 2'd1 || cmd == 2'd2)) begin colA = a; colB = bank; end
    mAddr = nxt;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 2'd0, 2'd0, '0, tag);
  endtask

  task automatic waitFor(input int target);
    while (mAddr != target) idle("R3");
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (actual() !== e.val) begin
        miscompares++;
        $display("FAIL %s: pins actual %h expected %h", e.tag, actual(), e.val);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;  // R1 reset state
    if (actual() !== pack(2'd3, 1'b1, 11'h400, 1, 1, 1, 1, 0)) begin
      miscompares++;
      $display("FAIL R1: reset pins actual %h expected %h", actual(),
               pack(2'd3, 1'b1, 11'h400, 1, 1, 1, 1, 0));
    end
    rstN = 1'b1;
    repeat (3) idle("R1");
    cyc(0, 1, 2'd0, 2'd1, 11'h123, "R8");          // activate from deselect rejected
    idle("R1");
    cyc(1, 0, 2'd0, 2'd2, 11'h7FF, "R2");          // mode load, A10 cleared
    repeat (5) idle("R3");                          // NOP, refresh loop
    waitFor(0);
    cyc(0, 1, 2'd1, 2'd0, 11'h055, "R8");          // read from NOP rejected
    waitFor(0);
    cyc(0, 1, 2'd0, 2'd2, 11'h5A5, "R4");          // activate bank 2, A10 set
    repeat (2) idle("R4");
    cyc(0, 1, 2'd1, 2'd2, 11'h012, "R5");
    idle("R5");
    cyc(0, 1, 2'd2, 2'd1, 11'h4FF, "R6");          // bit 10 dropped
    idle("R6");
    cyc(0, 1, 2'd0, 2'd0, 11'h001, "R8");          // activate while active rejected
    cyc(0, 1, 2'd3, 2'd2, 11'h000, "R7");          // precharge from active
    idle("R7");
    waitFor(2);
    cyc(0, 1, 2'd0, 2'd3, 11'h3FF, "R8");          // refresh exit not interruptible
    waitFor(1);
    cyc(1, 0, 2'd0, 2'd0, 11'h0AA, "R8");          // init during self-refresh
    waitFor(0);
    cyc(1, 1, 2'd0, 2'd3, 11'h2C3, "R9");          // init wins over activate
    idle("R9");
    for (int b = 0; b < 4; b++) begin
      waitFor(0);
      cyc(0, 1, 2'd3, 2'(b), 11'h7FF, "R7");       // precharge each bank from NOP
      idle("R7");
    end
    waitFor(0);
    cyc(0, 1, 2'd0, 2'd0, 11'h0F0, "R4");
    cyc(0, 1, 2'd2, 2'd3, 11'h333, "R6");
    cyc(0, 1, 2'd2, 2'd3, 11'h111, "R8");          // write from write word rejected
    idle("R6");
    repeat (3) idle("R4");
    @(negedge clk);
    @(negedge clk);
    finish();
  end

endmodule